// File: doc/BRIEF.md
# ADC Serial Port Device Emulator

This block stands in for the digital side of a serial analog-to-digital converter. It is written for synthesis and runs in the system clock domain. A stub conversion source supplies each result as a 16-bit magnitude field and a sign bit. The block measures a conversion time, accepts the result from the stub, and serves it on the serial data output as a 19-bit frame. During the same frame it decodes an 8-bit command on the serial data input, which can select a new channel and input mode.

The chip-select and serial clock pins come from outside the system clock domain. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies. The serial data input is sampled on each detected rising edge of the serial clock.

Tri-state is not modelled with real drivers. An output-enable flag follows the inverse of the synchronised chip-select.

The result arrives over a valid/ready stream. The block raises ready only when the conversion timer has expired. It holds ready until a beat is taken. The source may raise valid early, and it must keep its data steady until ready meets valid. A beat offered while ready is low is not taken.

Top module: `adc_port_emu`

## Requirements
- R1: While chip-select is high, `sdo_oe_o` is low, and serial clock edges change neither the frame position nor the channel selection.
- R2: While chip-select is low and no frame is in progress, `sdo_o` gives the live conversion state. It is 1 while a conversion is busy and 0 once the result has been accepted.
- R3: The frame is 19 bits. Bit 18 is the conversion flag (0) and is present before the first rising serial clock edge. Each falling edge presents the next lower bit. Bit 17 is 0, bit 16 is the sign, and bits 15..0 are the result, most significant bit first.
- R4: On the 19th falling edge `sdo_o` goes to 1 and a new conversion starts. `res_ready_o` rises again once `CONV_CYCLES` system cycles have passed.
- R5: The command is captured most significant bit first on rising serial clock edges. Bits 7..5 are the control field. Bit 4 is the mode bit (1 = single-ended), which appears on `single_o`. Bits 3..0 are the channel number, which appears on `chan_o`.
- R6: The mode and channel are written only when the control field is 3'b101. With 3'b100, 3'b000 or any other code they keep their value.
- R7: After reset the mode and channel are 0, a conversion is in progress, and `sdo_oe_o` is low.
- R8: A selection decoded during a frame appears on `chan_o` and `single_o` only at that frame's 19th falling edge.
- R9: If chip-select rises before the 19th falling edge, no conversion starts, no selection is applied, and the next frame repeats the same result.
- R10: `res_ready_o` is high only after the conversion time has expired and before a beat is taken. It stays high until `res_valid_i` meets it, and the beat is captured on that cycle.
- R11: Rising serial clock edges that arrive while a conversion is busy do not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Chip select, asynchronous, active low |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial command input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output-enable for the serial data output |
| res_valid_i | input | 1 | Result beat valid |
| res_ready_o | output | 1 | Result beat ready |
| res_data_i | input | 16 | Result field |
| res_sign_i | input | 1 | Result sign |
| chan_o | output | 4 | Selected channel |
| single_o | output | 1 | Selected mode, 1 = single-ended |

## Verification
Frames are read with random results and random signs, so that every frame bit position is compared against the expected word. Commands are drawn from three groups: update codes with random addresses, the two keep codes, and illegal control codes. This separates a correct control decode from a design that writes on any leading 1 or that ignores the enable bit. Directed cases cover the following:
- an aborted frame that carries an update code, which tells deferred application and result retention apart from eager behaviour;
- serial clock bursts with chip-select high;
- clocking while a conversion is busy;
- a result offered before ready, which exercises back-pressure.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
  localparam int FRAME_BITS = 19;
  localparam int CMD_BITS   = 8;
  localparam int RES_BITS   = 16;
  localparam logic [2:0] CTL_UPDATE = 3'b101;

  typedef struct packed {
    logic       single;
    logic [3:0] chan;
  } chsel_t;
endpackage

// File: rtl/adcp_sync.sv
module adcp_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= RST_VAL;
      s2   <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      s1   <= d;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;
endmodule

// File: rtl/adcp_conv_timer.sv
module adcp_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic take,
  output logic busy,
  output logic ready
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b0;
    end else if (busy && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready = busy && (cnt == LAST);
endmodule

// File: rtl/adcp_cmd_cap.sv
module adcp_cmd_cap
  import adcp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   en,
  input  logic   din,
  output logic   upd_valid,
  output chsel_t upd_sel
);
  localparam int NW = $clog2(CMD_BITS + 1);
  localparam logic [NW-1:0] FULL = NW'(CMD_BITS);

  logic [CMD_BITS-1:0] sh;
  logic [NW-1:0]       n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      n  <= '0;
    end else if (clr) begin
      sh <= '0;
      n  <= '0;
    end else if (en && n != FULL) begin
      sh <= {sh[CMD_BITS-2:0], din};
      n  <= n + 1'b1;
    end
  end

  assign upd_valid = (n == FULL) && (sh[7:5] == CTL_UPDATE);
  assign upd_sel   = chsel_t'(sh[4:0]);
endmodule

// File: rtl/adc_port_emu.sv
module adc_port_emu
  import adcp_pkg::*;
#(
  parameter int CONV_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_i,
  input  logic        sck_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  input  logic        res_valid_i,
  output logic        res_ready_o,
  input  logic [15:0] res_data_i,
  input  logic        res_sign_i,
  output logic [3:0]  chan_o,
  output logic        single_o
);
  localparam int FC = $clog2(FRAME_BITS);
  localparam logic [FC-1:0] LAST_FALL = FC'(FRAME_BITS - 1);

  logic cs_q, cs_rise_u, cs_fall_u;
  logic sck_q, sck_rise, sck_fall;
  logic busy, take, frame_end, cap_en, upd_valid;
  logic active, done;
  logic [FC-1:0] fall_cnt;
  logic [FRAME_BITS-1:0] word;
  chsel_t sel_q, upd_sel;

  adcp_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n_i), .q(cs_q), .rise(cs_rise_u), .fall(cs_fall_u)
  );
  adcp_sync #(.RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_q), .rise(sck_rise), .fall(sck_fall)
  );

  assign take      = res_valid_i && res_ready_o;
  assign frame_end = active && sck_fall && (fall_cnt == LAST_FALL);
  assign cap_en    = !cs_q && sck_rise && !done && (active || !busy);

  adcp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(frame_end), .take(take),
    .busy(busy), .ready(res_ready_o)
  );

  adcp_cmd_cap u_cap (
    .clk(clk), .rst_n(rst_n), .clr(cs_q), .en(cap_en), .din(sdi_i),
    .upd_valid(upd_valid), .upd_sel(upd_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done     <= 1'b0;
      fall_cnt <= '0;
    end else if (cs_q) begin
      active   <= 1'b0;
      done     <= 1'b0;
      fall_cnt <= '0;
    end else begin
      if (cap_en && !active) active <= 1'b1;
      if (active && sck_fall) begin
        if (fall_cnt == LAST_FALL) begin
          active   <= 1'b0;
          done     <= 1'b1;
          fall_cnt <= '0;
        end else begin
          fall_cnt <= fall_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      sel_q <= '0;
    end else begin
      if (take)                   word  <= {2'b00, res_sign_i, res_data_i};
      if (frame_end && upd_valid) sel_q <= upd_sel;
    end
  end

  assign sdo_o    = active ? word[LAST_FALL - fall_cnt] : busy;
  assign sdo_oe_o = ~cs_q;
  assign chan_o   = sel_q.chan;
  assign single_o = sel_q.single;
endmodule

// File: rtl/adcp_port_chk.sv
module adcp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_i,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic       res_valid_i,
  input logic       res_ready_o,
  input logic [3:0] chan_o,
  input logic       single_o
);
  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready_o && !res_valid_i) |=> res_ready_o);

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready_o && res_valid_i) |=> !res_ready_o);

  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready_o |-> sdo_o);

  // R8
  sel_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(chan_o) || !$stable(single_o)) |-> sdo_o);
endmodule

bind adc_port_emu adcp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .res_valid_i(res_valid_i), .res_ready_o(res_ready_o), .chan_o(chan_o), .single_o(single_o)
);

// File: tb/sim_adc_port_emu.sv
module sim_adc_port_emu;
  localparam int CONV = 40;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, res_valid = 1'b0, res_ready, res_sign = 1'b0, single;
  logic [15:0] res_data = '0;
  logic [3:0]  chan;

  int checks = 0, fails = 0;
  logic [4:0]  exp_sel = '0;
  logic [18:0] exp_w   = '0;

  always #10 clk = ~clk;

  adc_port_emu #(.CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .res_valid_i(res_valid), .res_ready_o(res_ready),
    .res_data_i(res_data), .res_sign_i(res_sign), .chan_o(chan), .single_o(single)
  );

  function automatic logic [18:0] word_of(input logic [15:0] d, input logic s);
    return {2'b00, s, d};
  endfunction

  function automatic logic [4:0] sel_after(input logic [7:0] cmd, input logic [4:0] old);
    return (cmd[7:5] == 3'b101) ? cmd[4:0] : old;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic give(input logic [15:0] d, input logic s);
    @(negedge clk);
    res_data  = d;
    res_sign  = s;
    res_valid = 1'b1;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    exp_w = word_of(d, s);
  endtask

  task automatic read_frame(input logic [7:0] cmd, input int stop_after,
                            output logic [18:0] bits, output logic post);
    bits = '0;
    post = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    bits[18] = sdo;
    for (int i = 0; i < 19; i++) begin
      sdi = (i < 8) ? cmd[7-i] : 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 18) bits[17-i] = sdo;
      else        post = sdo;
      // R8: selection unchanged mid-frame
      if (i == 10) chk("R8", {chan, single}, {exp_sel[3:0], exp_sel[4]});
      if (i + 1 == stop_after) break;
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [18:0] b;
    logic        p;
    logic [7:0]  cmd;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7", {sdo_oe, chan, single}, 6'd0);
    repeat (5) @(negedge clk);
    chk("R10", res_ready, 1'b0);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R2", {sdo_oe, sdo}, 2'b11);
    // R11: clocking while busy does not start a frame
    sck = 1'b1; repeat (HALF) @(negedge clk);
    sck = 1'b0; repeat (HALF) @(negedge clk);
    chk("R11", sdo, 1'b1);
    // R10: valid offered early, held off until ready
    give(16'hA5C3, 1'b1);
    repeat (HALF) @(negedge clk);
    chk("R2", sdo, 1'b0);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R1", sdo_oe, 1'b0);

    for (int n = 0; n < 24; n++) begin
      int kind;
      kind = n % 4;
      cmd  = 8'($urandom);
      if (kind == 0)      cmd[7:5] = 3'b101;
      else if (kind == 1) cmd[7:5] = 3'b100;
      else if (kind == 2) cmd = 8'h00;
      else if (cmd[7:5] == 3'b101) cmd[7:5] = 3'b111;
      read_frame(cmd, 19, b, p);
      chk("R3", b, exp_w);
      chk("R4", p, 1'b1);
      exp_sel = sel_after(cmd, exp_sel);
      chk((kind == 0) ? "R5" : "R6", {chan, single}, {exp_sel[3:0], exp_sel[4]});
      chk("R4", res_ready, 1'b0);
      give(16'($urandom), 1'($urandom));
    end

    // R9: aborted frame carrying an update code
    read_frame(8'b101_1_0110, 12, b, p);
    repeat (CONV + 10) @(negedge clk);
    chk("R9", res_ready, 1'b0);
    chk("R9", {chan, single}, {exp_sel[3:0], exp_sel[4]});
    read_frame(8'h00, 19, b, p);
    chk("R9", b, exp_w);
    give(16'h1234, 1'b0);

    // R1: serial clock with chip-select high
    for (int k = 0; k < 10; k++) begin
      sdi = 1'b1;
      sck = 1'b1; repeat (HALF) @(negedge clk);
      chk("R1", sdo_oe, 1'b0);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    read_frame(8'h00, 19, b, p);
    chk("R1", b, exp_w);
    chk("R1", {chan, single}, {exp_sel[3:0], exp_sel[4]});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule